// File: doc/BRIEF.md
# Byte/Word Group ALU with Status Flags

This block is the combinational arithmetic and logic unit of a small 8/16-bit processor datapath. One call takes two operands, a width select for byte or word operation, a two-bit class and a three-bit operation code within that class, and the incoming carry flag. It returns the result together with carry, overflow, zero, sign, parity and auxiliary-carry flags. It also returns a writeback strobe, which tells the register file whether to keep the result.

There are three classes. The binary class holds eight two-operand operations. The step class holds increment and decrement of the first operand. The unary class holds a flag-only AND test, bitwise NOT and two's-complement negate. All code points that are not assigned, and the fourth class, pass the first operand through unchanged and suppress writeback. The decoder upstream feeds the class and operation fields straight from the instruction's opcode and mode byte.

Top module: `grp_alu`

## Requirements
- R1: With class 0, the op code selects 0=add, 1=or, 2=add-with-carry, 3=subtract-with-borrow, 4=and, 5=subtract, 6=xor, 7=compare. Compare returns the subtraction result.
- R2: With the width bit at 0, only bits 7:0 of each operand are used, and result bits 15:8 are 0. With the width bit at 1, all 16 bits are used.
- R3: Add-with-carry adds the carry input. Subtract-with-borrow subtracts it as a borrow. Carry out is the carry from the top bit of the selected width for adds, and the borrow out of it for subtract, borrow-subtract and compare.
- R4: Overflow is set when the signed result of the selected width falls outside the signed range of that width. Add, step and negate operations obey this rule. Logic, NOT and pass-through operations report 0.
- R5: Zero is set when the selected-width result is 0. Sign equals bit 7 of the result for byte operations and bit 15 for word operations.
- R6: Parity is 1 when result bits 7:0 hold an even number of ones, for both widths.
- R7: And, or, xor and test (class 2, op 0, which returns a AND b) clear carry, overflow and auxiliary carry.
- R8: Auxiliary carry is the carry out of bit 3 for adds and increment. It is the borrow out of bit 3 for subtracts, decrement and negate.
- R9: Writeback is 0 for compare, test and every pass-through code, and 1 for all other operations.
- R10: With class 1, op 0 returns a+1 and op 1 returns a-1. The carry output equals the carry input.
- R11: With class 2, op 2 returns NOT a with carry equal to the carry input. Op 3 returns 0-a, with carry set exactly when the selected-width operand is nonzero.
- R12: Class 1 ops 2 to 7, class 2 ops 1 and 4 to 7, and all of class 3 return operand a at the selected width. Carry equals the carry input, and overflow and auxiliary carry are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand (destination side) |
| b_i | input | 16 | Second operand (source side) |
| wide_i | input | 1 | 0 = byte operation, 1 = word operation |
| cls_i | input | 2 | Operation class: 0 binary, 1 step, 2 unary, 3 none |
| op_i | input | 3 | Operation code within the class |
| cin_i | input | 1 | Incoming carry flag |
| res_o | output | 16 | Result, upper byte zero for byte operations |
| cf_o | output | 1 | Carry / borrow flag |
| of_o | output | 1 | Signed overflow flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| pf_o | output | 1 | Even parity of result bits 7:0 |
| af_o | output | 1 | Auxiliary carry out of bit 3 |
| wb_o | output | 1 | Result should be written back |

## Verification
The assertions rely on two assumptions: the inputs are settled two-state values, and the class and op fields arrive together in one step, so that no mixed decode is ever checked. The bench changes all inputs at once, away from any sampling point, and draws every field from its full range, including classes and codes that are not assigned. Byte-width stimulus leaves random data in the upper operand bytes. This checks that those bits never leak into the result or the flags.

// File: rtl/grp_alu_pkg.sv
package grp_alu_pkg;

  typedef enum logic [1:0] {
    CLS_BIN   = 2'd0,
    CLS_STEP  = 2'd1,
    CLS_UNARY = 2'd2,
    CLS_NONE  = 2'd3
  } alu_cls_e;

  typedef enum logic [2:0] {
    AK_ADD = 3'd0,
    AK_ADC = 3'd1,
    AK_SUB = 3'd2,
    AK_SBB = 3'd3,
    AK_INC = 3'd4,
    AK_DEC = 3'd5,
    AK_NEG = 3'd6
  } arith_kind_e;

  typedef enum logic [1:0] {
    LK_AND = 2'd0,
    LK_OR  = 2'd1,
    LK_XOR = 2'd2,
    LK_NOT = 2'd3
  } logic_kind_e;

  // Even parity of one byte: 1 when the count of ones is even.
  function automatic logic even_par8(input logic [7:0] v);
    return ~^v;
  endfunction

  // Keep only the selected width of a value.
  function automatic logic [15:0] fit_width(input logic [15:0] v, input logic wide);
    return wide ? v : {8'h00, v[7:0]};
  endfunction

endpackage

// File: rtl/grp_alu_arith.sv
module grp_alu_arith
  import grp_alu_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NIB = 4
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          wide,
  input  arith_kind_e   kind,
  output logic [DW-1:0] sum,
  output logic          cy,
  output logic          ovf,
  output logic          aux
);
  localparam int HW = DW / 2;

  logic [DW-1:0] x, y;
  logic          ci, is_sub;
  logic [DW:0]   sum_w;
  logic [HW:0]   sum_b;
  logic          raw_cy, sx, sy, sr, c_nib;

  always_comb begin
    x = a; y = b; ci = 1'b0; is_sub = 1'b0;
    unique case (kind)
      AK_ADD: ;
      AK_ADC: ci = cin;
      AK_SUB: begin y = ~b; ci = 1'b1;  is_sub = 1'b1; end
      AK_SBB: begin y = ~b; ci = ~cin;  is_sub = 1'b1; end
      AK_INC: begin y = DW'(1); end
      AK_DEC: begin y = ~DW'(1); ci = 1'b1; is_sub = 1'b1; end
      AK_NEG: begin x = '0; y = ~a; ci = 1'b1; is_sub = 1'b1; end
      default: ;
    endcase
  end

  assign sum_w  = {1'b0, x} + {1'b0, y} + (DW+1)'(ci);
  assign sum_b  = {1'b0, x[HW-1:0]} + {1'b0, y[HW-1:0]} + (HW+1)'(ci);
  assign sum    = wide ? sum_w[DW-1:0] : {{(DW-HW){1'b0}}, sum_b[HW-1:0]};
  assign raw_cy = wide ? sum_w[DW] : sum_b[HW];
  assign cy     = is_sub ? ~raw_cy : raw_cy;

  assign sx  = wide ? x[DW-1] : x[HW-1];
  assign sy  = wide ? y[DW-1] : y[HW-1];
  assign sr  = wide ? sum[DW-1] : sum[HW-1];
  assign ovf = (sx == sy) && (sr != sx);

  assign c_nib = x[NIB] ^ y[NIB] ^ sum[NIB];
  assign aux   = is_sub ? ~c_nib : c_nib;
endmodule

// File: rtl/grp_alu_logic.sv
module grp_alu_logic
  import grp_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          wide,
  input  logic_kind_e   kind,
  output logic [DW-1:0] res
);
  logic [DW-1:0] raw;

  always_comb begin
    unique case (kind)
      LK_AND:  raw = a & b;
      LK_OR:   raw = a | b;
      LK_XOR:  raw = a ^ b;
      default: raw = ~a;
    endcase
  end

  assign res = fit_width(raw, wide);
endmodule

// File: rtl/grp_alu_flags.sv
module grp_alu_flags
  import grp_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] res,
  input  logic          wide,
  output logic          zf,
  output logic          sf,
  output logic          pf
);
  localparam int HW = DW / 2;

  logic zero_byte, zero_word, neg_byte, neg_word;

  assign zero_byte = (res[HW-1:0] == '0);
  assign zero_word = zero_byte && (res[DW-1:HW] == '0);
  assign neg_byte  = res[HW-1];
  assign neg_word  = res[DW-1];

  assign zf = wide ? zero_word : zero_byte;
  assign sf = wide ? neg_word : neg_byte;
  assign pf = even_par8(res[7:0]);
endmodule

// File: rtl/grp_alu.sv
module grp_alu
  import grp_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  input  logic        wide_i,
  input  logic [1:0]  cls_i,
  input  logic [2:0]  op_i,
  input  logic        cin_i,
  output logic [15:0] res_o,
  output logic        cf_o,
  output logic        of_o,
  output logic        zf_o,
  output logic        sf_o,
  output logic        pf_o,
  output logic        af_o,
  output logic        wb_o
);
  alu_cls_e    cls;
  arith_kind_e ak;
  logic_kind_e lk;
  logic        sel_arith, sel_logic, keep_cf, wb_en;
  logic        sel_step, sel_neg;
  logic [DW-1:0] ar_sum, lg_res;
  logic          ar_cy, ar_ovf, ar_aux;

  assign cls = alu_cls_e'(cls_i);

  always_comb begin
    sel_arith = 1'b0; sel_logic = 1'b0; keep_cf = 1'b0; wb_en = 1'b0;
    ak = AK_ADD; lk = LK_AND;
    unique case (cls)
      CLS_BIN: begin
        wb_en = 1'b1;
        unique case (op_i)
          3'd0: begin sel_arith = 1'b1; ak = AK_ADD; end
          3'd1: begin sel_logic = 1'b1; lk = LK_OR;  end
          3'd2: begin sel_arith = 1'b1; ak = AK_ADC; end
          3'd3: begin sel_arith = 1'b1; ak = AK_SBB; end
          3'd4: begin sel_logic = 1'b1; lk = LK_AND; end
          3'd5: begin sel_arith = 1'b1; ak = AK_SUB; end
          3'd6: begin sel_logic = 1'b1; lk = LK_XOR; end
          default: begin sel_arith = 1'b1; ak = AK_SUB; wb_en = 1'b0; end
        endcase
      end
      CLS_STEP: begin
        if (op_i == 3'd0) begin
          sel_arith = 1'b1; ak = AK_INC; keep_cf = 1'b1; wb_en = 1'b1;
        end else if (op_i == 3'd1) begin
          sel_arith = 1'b1; ak = AK_DEC; keep_cf = 1'b1; wb_en = 1'b1;
        end
      end
      CLS_UNARY: begin
        unique case (op_i)
          3'd0: begin sel_logic = 1'b1; lk = LK_AND; end
          3'd2: begin sel_logic = 1'b1; lk = LK_NOT; keep_cf = 1'b1; wb_en = 1'b1; end
          3'd3: begin sel_arith = 1'b1; ak = AK_NEG; wb_en = 1'b1; end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  assign sel_step = sel_arith && (ak == AK_INC || ak == AK_DEC);
  assign sel_neg  = sel_arith && (ak == AK_NEG);

  grp_alu_arith #(.DW(DW)) arith_i (
    .a(a_i), .b(b_i), .cin(cin_i), .wide(wide_i), .kind(ak),
    .sum(ar_sum), .cy(ar_cy), .ovf(ar_ovf), .aux(ar_aux)
  );

  grp_alu_logic #(.DW(DW)) logic_i (
    .a(a_i), .b(b_i), .wide(wide_i), .kind(lk), .res(lg_res)
  );

  always_comb begin
    if (sel_arith) begin
      res_o = ar_sum;
      cf_o  = keep_cf ? cin_i : ar_cy;
      of_o  = ar_ovf;
      af_o  = ar_aux;
    end else if (sel_logic) begin
      res_o = lg_res;
      cf_o  = keep_cf ? cin_i : 1'b0;
      of_o  = 1'b0;
      af_o  = 1'b0;
    end else begin
      res_o = fit_width(a_i, wide_i);
      cf_o  = cin_i;
      of_o  = 1'b0;
      af_o  = 1'b0;
    end
  end

  assign wb_o = wb_en;

  grp_alu_flags #(.DW(DW)) flags_i (
    .res(res_o), .wide(wide_i), .zf(zf_o), .sf(sf_o), .pf(pf_o)
  );
endmodule

// File: rtl/grp_alu_chk.sv
module grp_alu_chk (
  input logic [15:0] a_i,
  input logic [1:0]  cls_i,
  input logic [2:0]  op_i,
  input logic        wide_i,
  input logic        cin_i,
  input logic [15:0] res_o,
  input logic        cf_o,
  input logic        of_o,
  input logic        zf_o,
  input logic        pf_o,
  input logic        af_o,
  input logic        wb_o,
  input logic        sel_logic,
  input logic        sel_step,
  input logic        sel_neg
);
  always_comb begin
    a_r6_parity_low_byte: assert (pf_o == ((($countones(res_o[7:0])) % 2) == 0))
      else $error("parity flag disagrees with result low byte");
    a_r5_zero_tracks_width: assert (zf_o == (wide_i ? (res_o == 16'h0) : (res_o[7:0] == 8'h0)))
      else $error("zero flag disagrees with result");
    if (!wide_i) begin
      a_r2_upper_byte_clear: assert (res_o[15:8] == 8'h00)
        else $error("byte operation left upper result bits");
    end
    if (sel_logic) begin
      a_r7_logic_clears_flags: assert (!of_o && !af_o && (!cf_o || cin_i))
        else $error("logic operation set carry, overflow or aux");
    end
    if (sel_step) begin
      a_r10_step_keeps_carry: assert (cf_o == cin_i)
        else $error("step operation altered carry");
    end
    if (sel_neg) begin
      a_r11_neg_carry: assert (cf_o == (wide_i ? (a_i != 16'h0) : (a_i[7:0] != 8'h0)))
        else $error("negate carry disagrees with operand");
    end
    if ((cls_i == 2'd0 && op_i == 3'd7) || (cls_i == 2'd2 && op_i == 3'd0) || cls_i == 2'd3) begin
      a_r9_no_writeback: assert (!wb_o)
        else $error("writeback raised for compare, test or pass");
    end
  end
endmodule

bind grp_alu grp_alu_chk chk_i (
  .a_i(a_i), .cls_i(cls_i), .op_i(op_i), .wide_i(wide_i), .cin_i(cin_i),
  .res_o(res_o), .cf_o(cf_o), .of_o(of_o), .zf_o(zf_o), .pf_o(pf_o),
  .af_o(af_o), .wb_o(wb_o),
  .sel_logic(sel_logic), .sel_step(sel_step), .sel_neg(sel_neg)
);

// File: tb/grp_alu_tb_top.sv
module grp_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] a_i = '0, b_i = '0;
  logic        wide_i = 1'b0, cin_i = 1'b0;
  logic [1:0]  cls_i = '0;
  logic [2:0]  op_i = '0;
  logic [15:0] res_o;
  logic cf_o, of_o, zf_o, sf_o, pf_o, af_o, wb_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  grp_alu dut_i (
    .a_i(a_i), .b_i(b_i), .wide_i(wide_i), .cls_i(cls_i), .op_i(op_i),
    .cin_i(cin_i), .res_o(res_o), .cf_o(cf_o), .of_o(of_o), .zf_o(zf_o),
    .sf_o(sf_o), .pf_o(pf_o), .af_o(af_o), .wb_o(wb_o)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s cls=%0d op=%0d w=%0d a=%h b=%h c=%0d got=%h exp=%h",
               tag, cls_i, op_i, wide_i, a_i, b_i, cin_i, got, exp);
    end
  endtask

  function automatic int to_signed(input int v, input int half);
    return (v >= half) ? v - 2*half : v;
  endfunction

  // kind: 0 pass, 1 add-like, 2 sub-like, 3 logic, 4 not
  task automatic apply(input logic [1:0] cls, input logic [2:0] op,
                       input logic [15:0] a, input logic [15:0] b,
                       input logic w, input logic c);
    int mask, half, am, bm, lhs, rhs, cc, u, s, res, kind, ones;
    int e_cf, e_of, e_af, e_wb;
    string rtag, ctag;
    @(posedge clk);
    a_i = a; b_i = b; wide_i = w; cls_i = cls; op_i = op; cin_i = c;
    mask = w ? 32'hFFFF : 32'hFF;
    half = (mask + 1) / 2;
    am = int'(a) & mask;
    bm = int'(b) & mask;
    kind = 0; lhs = am; rhs = bm; cc = 0; res = am;
    e_cf = c; e_wb = 0; rtag = "R12"; ctag = "R12";
    case (cls)
      2'd0: begin
        rtag = "R1"; ctag = "R3"; e_wb = (op != 3'd7);
        case (op)
          3'd0: kind = 1;
          3'd2: begin kind = 1; cc = c; end
          3'd3: begin kind = 2; cc = c; end
          3'd5, 3'd7: kind = 2;
          3'd1: begin kind = 3; res = am | bm; ctag = "R7"; end
          3'd4: begin kind = 3; res = am & bm; ctag = "R7"; end
          default: begin kind = 3; res = am ^ bm; ctag = "R7"; end
        endcase
      end
      2'd1: begin
        if (op == 3'd0) begin kind = 1; rhs = 1; rtag = "R10"; ctag = "R10"; e_wb = 1; end
        if (op == 3'd1) begin kind = 2; rhs = 1; rtag = "R10"; ctag = "R10"; e_wb = 1; end
      end
      2'd2: begin
        if (op == 3'd0) begin kind = 3; res = am & bm; rtag = "R7"; ctag = "R7"; end
        if (op == 3'd2) begin kind = 4; res = (~am) & mask; rtag = "R11"; ctag = "R11"; e_wb = 1; end
        if (op == 3'd3) begin kind = 2; lhs = 0; rhs = am; rtag = "R11"; ctag = "R11"; e_wb = 1; end
      end
      default: ;
    endcase
    e_of = 0; e_af = 0;
    if (kind == 1) begin
      u = lhs + rhs + cc;
      res = u & mask;
      s = to_signed(lhs, half) + to_signed(rhs, half) + cc;
      e_of = (s < -half || s >= half);
      e_af = ((lhs & 15) + (rhs & 15) + cc) > 15;
      if (ctag != "R10") e_cf = (u > mask);
    end else if (kind == 2) begin
      u = lhs - rhs - cc;
      res = u & mask;
      s = to_signed(lhs, half) - to_signed(rhs, half) - cc;
      e_of = (s < -half || s >= half);
      e_af = ((lhs & 15) - (rhs & 15) - cc) < 0;
      if (ctag != "R10") e_cf = (u < 0);
    end else if (kind == 3) begin
      e_cf = 0;
    end
    ones = 0;
    for (int i = 0; i < 8; i++) ones += (res >> i) & 1;
    @(negedge clk);
    chk(rtag, int'(res_o), res);
    if (!w) chk("R2 upper byte", int'(res_o[15:8]), 0);
    chk(ctag, int'(cf_o), e_cf);
    chk("R4 overflow", int'(of_o), e_of);
    chk("R5 zero", int'(zf_o), int'(res == 0));
    chk("R5 sign", int'(sf_o), int'(res >= half));
    chk("R6 parity", int'(pf_o), int'((ones % 2) == 0));
    chk("R8 aux", int'(af_o), e_af);
    chk("R9 writeback", int'(wb_o), e_wb);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    // idle inputs (all zero): an add of zeros
    @(negedge clk);
    chk("R1 idle result", int'(res_o), 0);
    chk("R5 idle zero", int'(zf_o), 1);
    chk("R6 idle parity", int'(pf_o), 1);
    chk("R9 idle writeback", int'(wb_o), 1);
    // directed corners
    apply(2'd0, 3'd0, 16'h007F, 16'h0001, 1'b0, 1'b0); // R4 byte add overflow
    apply(2'd0, 3'd5, 16'h0080, 16'h0001, 1'b0, 1'b0); // R4 byte sub overflow
    apply(2'd0, 3'd3, 16'h0000, 16'h0000, 1'b1, 1'b1); // R3 borrow chain
    apply(2'd0, 3'd2, 16'hFFFF, 16'h0000, 1'b1, 1'b1); // R3 carry wrap
    apply(2'd0, 3'd7, 16'h1234, 16'h1234, 1'b1, 1'b0); // R9 compare equal
    apply(2'd1, 3'd0, 16'hFFFF, 16'h0000, 1'b1, 1'b0); // R10 inc wrap
    apply(2'd1, 3'd1, 16'h0000, 16'h0000, 1'b0, 1'b1); // R10 dec wrap
    apply(2'd2, 3'd3, 16'h0000, 16'h0000, 1'b1, 1'b1); // R11 neg zero
    apply(2'd2, 3'd3, 16'h8000, 16'h0000, 1'b1, 1'b0); // R11 neg min word
    apply(2'd2, 3'd3, 16'hAB80, 16'h0000, 1'b0, 1'b0); // R11 neg min byte
    apply(2'd2, 3'd2, 16'h00F0, 16'h0000, 1'b0, 1'b1); // R11 not
    apply(2'd2, 3'd0, 16'hFF0F, 16'h0FF0, 1'b1, 1'b1); // R7 test
    apply(2'd0, 3'd6, 16'h0100, 16'h0000, 1'b1, 1'b0); // R6 high byte ignored
    apply(2'd3, 3'd5, 16'hBEEF, 16'h1111, 1'b0, 1'b1); // R12 pass byte
    apply(2'd1, 3'd6, 16'hBEEF, 16'h1111, 1'b1, 1'b0); // R12 pass word
    apply(2'd0, 3'd0, 16'h0008, 16'h0008, 1'b0, 1'b0); // R8 nibble carry
    for (int n = 0; n < N_RANDOM; n++) begin
      apply(2'($urandom), 3'($urandom), 16'($urandom), 16'($urandom),
            1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements got=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule